// File: doc/BRIEF.md
# Masked GPIO Port Register Block

This block is one 32-bit general-purpose I/O port sitting behind a small memory-mapped command interface. Software sets a direction bit per pin and drives the port's output latch. It can write the whole latch in one access, or set or clear any group of bits without a read-modify-write. A mask register fences off pins. Bits with mask 1 are protected from every latch-modifying write and read back as 0 from the pin register. This lets one driver own a subset of the port while other code touches the rest.

The command interface follows valid/ready rules. `cmd_ready` is tied high, so a command is accepted in every cycle where `cmd_valid` is high and the requester never sees back-pressure. A read answers on `rsp_valid`/`rsp_rdata` exactly one cycle after it is accepted. The response has no ready, so the requester must be able to take it in that cycle. `cmd_be` selects the byte lanes a write touches, which gives byte, half-word and word writes. Reads always return the full word. Pad levels enter through a two-flop synchronizer.

Register index (`cmd_addr`): 0 direction, 1 mask, 2 pin value, 3 set, 4 clear. Indices 5 to 7 read as 0 and ignore writes.

Top module: `gpio_masked_port`

## Requirements
- R1: A write changes only the bits in byte lanes whose `cmd_be` bit is 1. `cmd_be[k]` covers data bits 8k+7..8k.
- R2: A write to the pin value register (index 2) loads the output latch with the written data at every enabled bit whose mask bit is 0. All other latch bits keep their value.
- R3: A write to the set register (index 3) forces a latch bit to 1 where the data bit is 1, its lane is enabled and its mask bit is 0. Every other bit is left as it was.
- R4: A write to the clear register (index 4) forces a latch bit to 0 where the data bit is 1, its lane is enabled and its mask bit is 0. Every other bit is left as it was.
- R5: `pad_oe` equals the direction register, where 1 means output and 0 means input. `pad_out` equals the output latch.
- R6: After reset the direction register, the mask register and the output latch are all 0.
- R7: A read of the pin value register returns the pad level sampled two clock edges earlier (two-flop synchronizer), ANDed with the inverted mask.
- R8: A read of the set register returns the output latch, and a read of the clear register returns 0.
- R9: `cmd_ready` is always 1. `rsp_valid` is 1 exactly in the cycle after a read is accepted.
- R10: The direction and mask registers read back their last written value. Writes to indices 5 to 7 change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always 1) |
| cmd_we | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 3 | Register index |
| cmd_wdata | input | 32 | Write data |
| cmd_be | input | 4 | Byte lane enables for writes |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | 32 | Pad levels (asynchronous) |
| pad_out | output | 32 | Output latch value to pads |
| pad_oe | output | 32 | Per-pin output enable |

## Verification
Two things can coincide in a single cycle: a pin-register read capturing the synchronizer output, and a new pad level arriving at that output. The mask can also be rewritten in the cycle just before the read. The bench toggles `pad_in` on every cycle while it issues back-to-back reads and mask writes, with random byte enables. A behavioural model tracks the two sampling stages and judges each response against the pad value from exactly two edges earlier, masked by the mask as it stood when the read was accepted.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_DIR  = 3'd0,
    REG_MASK = 3'd1,
    REG_PIN  = 3'd2,
    REG_SET  = 3'd3,
    REG_CLR  = 3'd4
  } gp_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  gp_reg_e          wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] lane_mask,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] mask_q,
  output logic [WIDTH-1:0] lat_q
);
  logic [WIDTH-1:0] touch;
  assign touch = lane_mask & ~mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      mask_q <= '0;
      lat_q  <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        REG_DIR:  dir_q  <= (dir_q  & ~lane_mask) | (wr_data & lane_mask);
        REG_MASK: mask_q <= (mask_q & ~lane_mask) | (wr_data & lane_mask);
        REG_PIN:  lat_q  <= (lat_q & ~touch) | (wr_data & touch);
        REG_SET:  lat_q  <= lat_q | (wr_data & touch);
        REG_CLR:  lat_q  <= lat_q & ~(wr_data & touch);
        default:  ;
      endcase
    end
  end

  // Latch bits under a set mask never move on the next edge.
  p_mask_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((lat_q ^ $past(lat_q)) & $past(mask_q)) == '0));

  // A set write never lowers a latch bit.
  p_set_never_falls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == REG_SET) |=> ((~lat_q & $past(lat_q)) == '0));

  // A clear write never raises a latch bit.
  p_clr_never_rises_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == REG_CLR) |=> ((lat_q & ~$past(lat_q)) == '0));

  // Disabled byte lanes of the direction register hold their value.
  p_lane_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == REG_DIR) |=> (((dir_q ^ $past(dir_q)) & ~$past(lane_mask)) == '0));
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic                 cmd_we,
  input  logic [REG_IDX_W-1:0] cmd_addr,
  input  logic [31:0]          cmd_wdata,
  input  logic [3:0]           cmd_be,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  input  logic [31:0]          pad_in,
  output logic [31:0]          pad_out,
  output logic [31:0]          pad_oe
);
  localparam int unsigned LANES = WIDTH / 8;

  gp_reg_e          sel;
  logic [WIDTH-1:0] lane_mask;
  logic [WIDTH-1:0] dir_q, mask_q, lat_q, pin_sync;
  logic [WIDTH-1:0] rd_mux;
  logic             wr_en, rd_en;

  assign cmd_ready = 1'b1;
  assign sel       = gp_reg_e'(cmd_addr);
  assign wr_en     = cmd_valid & cmd_we;
  assign rd_en     = cmd_valid & ~cmd_we;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_mask[l*8 +: 8] = {8{cmd_be[l]}};
  end

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (sel),
    .wr_data   (cmd_wdata),
    .lane_mask (lane_mask),
    .dir_q     (dir_q),
    .mask_q    (mask_q),
    .lat_q     (lat_q)
  );

  always_comb begin
    case (sel)
      REG_DIR:  rd_mux = dir_q;
      REG_MASK: rd_mux = mask_q;
      REG_PIN:  rd_mux = pin_sync & ~mask_q;
      REG_SET:  rd_mux = lat_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= rd_mux;
    end
  end

  assign pad_out = lat_q;
  assign pad_oe  = dir_q;

  p_rsp_follows_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_valid);

  p_no_stray_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rsp_valid);

  p_pin_read_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == REG_PIN) |=> ((rsp_rdata & $past(mask_q)) == '0));

  p_clr_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == REG_CLR) |=> (rsp_rdata == '0));
endmodule

// File: tb/test_gpio_masked_port.sv
module test_gpio_masked_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_we = 1'b0;
  logic [2:0]  cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic [3:0]  cmd_be = '0;
  logic [31:0] pad_in = '0;
  logic        cmd_ready, rsp_valid;
  logic [31:0] rsp_rdata, pad_out, pad_oe;

  int checks = 0;
  int fails  = 0;

  // Model state
  logic [31:0] m_dir = '0, m_mask = '0, m_lat = '0, m_s1 = '0, m_s2 = '0, m_rd = '0;
  logic        m_rv = 1'b0;

  always #10 clk = ~clk;

  gpio_masked_port i_gpio_masked_port (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_be(cmd_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] lanes(input logic [3:0] be);
    logic [31:0] m = '0;
    for (int l = 0; l < 4; l++) if (be[l]) m[l*8 +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic model_edge();
    logic [31:0] eff, rd;
    if (!rst_n) begin
      m_dir = '0; m_mask = '0; m_lat = '0; m_s1 = '0; m_s2 = '0; m_rv = 0; m_rd = '0;
      return;
    end
    eff = lanes(cmd_be) & ~m_mask;
    case (cmd_addr)
      3'd0: rd = m_dir;
      3'd1: rd = m_mask;
      3'd2: rd = m_s2 & ~m_mask;
      3'd3: rd = m_lat;
      default: rd = '0;
    endcase
    m_rv = cmd_valid && !cmd_we;
    if (m_rv) m_rd = rd;
    if (cmd_valid && cmd_we) begin
      case (cmd_addr)
        3'd0: m_dir  = (m_dir  & ~lanes(cmd_be)) | (cmd_wdata & lanes(cmd_be));
        3'd1: m_mask = (m_mask & ~lanes(cmd_be)) | (cmd_wdata & lanes(cmd_be));
        3'd2: m_lat  = (m_lat & ~eff) | (cmd_wdata & eff);
        3'd3: m_lat  = m_lat | (cmd_wdata & eff);
        3'd4: m_lat  = m_lat & ~(cmd_wdata & eff);
        default: ;
      endcase
    end
    m_s2 = m_s1;
    m_s1 = pad_in;
  endtask

  task automatic compare();
    chk("R9 cmd_ready", {31'd0, cmd_ready}, 32'd1);
    chk("R9 rsp_valid", {31'd0, rsp_valid}, {31'd0, m_rv});
    if (m_rv) chk("R1 R7 R8 R10 rsp_rdata", rsp_rdata, m_rd);
    chk("R2 R3 R4 pad_out", pad_out, m_lat);
    chk("R5 pad_oe", pad_oe, m_dir);
  endtask

  task automatic cyc(input logic v, input logic we, input logic [2:0] a,
                     input logic [31:0] d, input logic [3:0] be);
    cmd_valid = v; cmd_we = we; cmd_addr = a; cmd_wdata = d; cmd_be = be;
    @(posedge clk);
    model_edge();
    #5;
    compare();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) cyc(0, 0, 0, 0, 0);
    // R6: reset state at the pads
    chk("R6 pad_oe after reset", pad_oe, 32'd0);
    chk("R6 pad_out after reset", pad_out, 32'd0);
    rst_n = 1'b1;
    // R6 / R8: reads of all registers after reset
    for (int a = 0; a < 8; a++) cyc(1, 0, a[2:0], 0, 4'hF);
    cyc(0, 0, 0, 0, 0);
    // R1: byte-lane write of direction
    cyc(1, 1, 3'd0, 32'hFFFF_FFFF, 4'b0001);
    cyc(1, 0, 3'd0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R1 single lane dir", rsp_rdata, 32'h0000_00FF);
    cyc(1, 1, 3'd0, 32'hFFFF_FFFF, 4'b1100);
    cyc(1, 1, 3'd0, 32'hFFFF_FFFF, 4'hF);
    // R2: full latch write then readback via set register (R8)
    cyc(1, 1, 3'd2, 32'hA5A5_5A5A, 4'hF);
    cyc(1, 0, 3'd3, 0, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R8 set reads latch", rsp_rdata, 32'hA5A5_5A5A);
    // R10 / R2 / R3 / R4 with mask on byte 1
    cyc(1, 1, 3'd1, 32'h0000_FF00, 4'hF);
    cyc(1, 0, 3'd1, 0, 0);
    cyc(1, 1, 3'd2, 32'h0000_0000, 4'hF);
    chk("R2 masked byte kept", pad_out, 32'h0000_5A00);
    cyc(1, 1, 3'd3, 32'hFFFF_FFFF, 4'hF);
    chk("R3 set honours mask", pad_out, 32'hFFFF_5AFF);
    cyc(1, 1, 3'd4, 32'h0F0F_0F0F, 4'b0101);
    chk("R4 clear honours lanes and mask", pad_out, 32'hFFF0_5AF0);
    cyc(1, 0, 3'd4, 0, 0);
    // R7: synchronizer latency
    pad_in = 32'h1234_5678;
    cyc(1, 0, 3'd2, 0, 0);
    cyc(1, 0, 3'd2, 0, 0);
    cyc(1, 0, 3'd2, 0, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R7 pin read after two edges", rsp_rdata, 32'h1234_0078);
    // R10: unused indices
    cyc(1, 1, 3'd5, 32'hFFFF_FFFF, 4'hF);
    cyc(1, 1, 3'd7, 32'hFFFF_FFFF, 4'hF);
    cyc(1, 0, 3'd6, 0, 0);
    // Concurrent pad motion, mask changes and reads
    for (int i = 0; i < 600; i++) begin
      pad_in = $urandom;
      cyc(($urandom % 4) != 0, ($urandom % 2) == 1, 3'($urandom % 6),
          ($urandom % 3 == 0) ? 32'hFFFF_FFFF : $urandom, 4'($urandom));
    end
    summary();
    $finish;
  end
endmodule